// File: doc/BRIEF.md
# Seconds/Minutes Watchdog Timer

This block is a down-counting watchdog that software drives through four byte-wide registers selected by a two-bit address. The registers are a control byte, a configuration byte, and the low and high halves of a 16-bit count. Software arms or restarts the timer by writing the count. It writes the high half first, then the low half. Writing the low half loads the whole value into the live counter. A loaded value of zero stops the timer. Any other value starts it, or restarts it if it is already running.

The counter decrements on a time base that the configuration byte selects. One choice is a 1 Hz tick supplied at the `tick1Hz` input. The other is a minute tick that the block derives from it with an internal divide-by-60 prescaler. The prescaler restarts on every reload.

When the count runs out, the block stops itself. It sets a sticky status flag in the control byte, which software clears by writing 1 to it. It also emits up to three single-cycle pulses, each with its own enable in the configuration byte: a keyboard-controller reset request, a power-good drop, and a generic timeout strobe. Parameters select a narrow variant that uses only the low count byte, and a variant in which one control bit, once set, survives later writes.

Top module: `sec_min_watchdog`

## Requirements
- R1: After reset, all four registers read 0, the timer is stopped, and all three pulse outputs are low.
- R2: A write to address 2 (count low) loads the counter with {address-3 byte, written byte}. If that value is nonzero, the timer runs. Address 2 reads back the live counter bits 7:0 and address 3 reads back bits 15:8.
- R3: A write to address 2 that yields a zero count stops the timer. The counter then reads 0, and later ticks produce no pulse and no status change.
- R4: With configuration bit 7 = 1 (seconds), the counter drops by one on each `tick1Hz` strobe. After a load of N, expiry happens on the Nth tick.
- R5: With configuration bit 7 = 0 (minutes), the counter drops by one on every 60th tick, so a load of N expires on tick N*60. Any reload clears the partial minute.
- R6: On expiry, control bit 0 becomes 1 and the counter stays stopped at 0. Further ticks produce no pulse. Writing control with bit 0 = 1 clears the flag, and writing it with bit 0 = 0 leaves the flag set.
- R7: `kbdResetReq` pulses high for exactly one clock, in the cycle after the expiring tick, if and only if configuration bit 6 is 1.
- R8: `pwrGoodDrop` pulses for one clock on expiry if and only if configuration bit 4 is 1. `timeoutPulse` does the same, gated by configuration bit 5.
- R9: Configuration bits 3:0 are stored and read back at address 1. They have no effect on the count or on the outputs.
- R10: With WIDE_COUNT = 0, the address-3 byte is ignored on load and address 3 reads 0.
- R11: With KEEP_CTRL_B3 = 1, control bit 3 cannot be cleared by a write once it is set. With the default variant, control bits 7:1 take the written value.
- R12: A count write in the same cycle as a tick takes priority. The tick is lost, and the counter holds the newly written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tick1Hz | input | 1 | One-cycle strobe once per second |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Write address: 0 control, 1 configuration, 2 count low, 3 count high |
| wrData | input | 8 | Write data |
| rdAddr | input | 2 | Read address, same map as write |
| rdData | output | 8 | Combinational read data |
| kbdResetReq | output | 1 | Keyboard-controller reset request pulse |
| pwrGoodDrop | output | 1 | Power-good deassertion pulse |
| timeoutPulse | output | 1 | Generic timeout strobe |

## Verification
The hardest case to reach from the ports is the minute prescaler being cleared mid-count. Its state is never visible, so the only evidence is when expiry lands. The stimulus runs 30 ticks into a minute, reloads a one-minute count, and then checks two things: 59 further ticks pass with no pulse, and the 60th tick expires. A stale prescaler would fire 30 ticks early. The write-against-tick collision is reached by raising the count write and the tick strobe in the same cycle. The narrow and sticky-bit variants run as a second instance that shares the stimulus.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int CNT_W = 16;

  localparam logic [1:0] ADDR_CTRL   = 2'd0;
  localparam logic [1:0] ADDR_CFG    = 2'd1;
  localparam logic [1:0] ADDR_CNT_LO = 2'd2;
  localparam logic [1:0] ADDR_CNT_HI = 2'd3;

  localparam int CFG_SECONDS = 7;
  localparam int CFG_KBD     = 6;
  localparam int CFG_TOUT    = 5;
  localparam int CFG_PGOOD   = 4;

  typedef struct packed {
    logic             load;
    logic [CNT_W-1:0] loadValue;
    logic             decrement;
    logic             prescClear;
    logic             prescStep;
  } wdtStrobes_t;
endpackage

// File: rtl/wdt_datapath.sv
module wdt_datapath
  import wdt_pkg::*;
#(
  parameter int PRESC_MAX = 59
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  wdtStrobes_t               strobes,
  output logic [CNT_W-1:0]          counter,
  output logic [$clog2(PRESC_MAX+1)-1:0] presc,
  output logic                      cntIsOne,
  output logic                      prescWrap
);
  localparam int PRESC_W = $clog2(PRESC_MAX + 1);
  localparam logic [PRESC_W-1:0] PRESC_TOP = PRESC_W'(PRESC_MAX);

  // live down counter; a load always overrides a decrement
  always_ff @(posedge clk) begin
    if (!rstN) begin
      counter <= '0;
    end else if (strobes.load) begin
      counter <= strobes.loadValue;
    end else if (strobes.decrement && counter != '0) begin
      counter <= counter - 1'b1;
    end
  end

  // minute prescaler, counts 0..PRESC_MAX
  always_ff @(posedge clk) begin
    if (!rstN) begin
      presc <= '0;
    end else if (strobes.prescClear) begin
      presc <= '0;
    end else if (strobes.prescStep) begin
      presc <= prescWrap ? '0 : presc + 1'b1;
    end
  end

  assign cntIsOne  = (counter == CNT_W'(1));
  assign prescWrap = (presc == PRESC_TOP);
endmodule

// File: rtl/wdt_ctrl.sv
module wdt_ctrl
  import wdt_pkg::*;
#(
  parameter bit WIDE_COUNT   = 1'b1,
  parameter bit KEEP_CTRL_B3 = 1'b0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tick1Hz,
  input  logic             wrEn,
  input  logic [1:0]       wrAddr,
  input  logic [7:0]       wrData,
  input  logic             cntIsOne,
  input  logic             prescWrap,
  output wdtStrobes_t      strobes,
  output logic [7:0]       ctrlReg,
  output logic [7:0]       cfgReg,
  output logic [7:0]       hiReg,
  output logic             running,
  output logic             kbdResetReq,
  output logic             pwrGoodDrop,
  output logic             timeoutPulse
);
  localparam logic [6:0] KEEP_MASK = KEEP_CTRL_B3 ? 7'b0000100 : 7'b0000000;

  logic [6:0]       ctrlHi;
  logic             status;
  logic             loadReq;
  logic [CNT_W-1:0] loadValue;
  logic             baseTick;
  logic             expire;
  logic             runningNext;

  assign loadReq = wrEn && (wrAddr == ADDR_CNT_LO);

  generate
    if (WIDE_COUNT) begin : g_wide
      assign loadValue = {hiReg, wrData};
    end else begin : g_narrow
      assign loadValue = {8'h00, wrData};
    end
  endgenerate

  always_comb begin
    baseTick = tick1Hz && running && (cfgReg[CFG_SECONDS] || prescWrap);
    expire   = baseTick && !loadReq && cntIsOne;

    strobes.load       = loadReq;
    strobes.loadValue  = loadValue;
    strobes.decrement  = baseTick && !loadReq;
    strobes.prescClear = loadReq;
    strobes.prescStep  = tick1Hz && running && !cfgReg[CFG_SECONDS] && !loadReq;

    if (loadReq)     runningNext = (loadValue != '0);
    else if (expire) runningNext = 1'b0;
    else             runningNext = running;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgReg       <= '0;
      hiReg        <= '0;
      ctrlHi       <= '0;
      status       <= 1'b0;
      running      <= 1'b0;
      kbdResetReq  <= 1'b0;
      pwrGoodDrop  <= 1'b0;
      timeoutPulse <= 1'b0;
    end else begin
      if (wrEn && wrAddr == ADDR_CFG)    cfgReg <= wrData;
      if (wrEn && wrAddr == ADDR_CNT_HI) hiReg  <= wrData;
      if (wrEn && wrAddr == ADDR_CTRL)   ctrlHi <= wrData[7:1] | (ctrlHi & KEEP_MASK);

      if (expire)                                    status <= 1'b1;
      else if (wrEn && wrAddr == ADDR_CTRL && wrData[0]) status <= 1'b0;

      running      <= runningNext;
      kbdResetReq  <= expire && cfgReg[CFG_KBD];
      pwrGoodDrop  <= expire && cfgReg[CFG_PGOOD];
      timeoutPulse <= expire && cfgReg[CFG_TOUT];
    end
  end

  assign ctrlReg = {ctrlHi, status};
endmodule

// File: rtl/sec_min_watchdog.sv
module sec_min_watchdog
  import wdt_pkg::*;
#(
  parameter bit WIDE_COUNT    = 1'b1,
  parameter bit KEEP_CTRL_B3  = 1'b0,
  parameter int TICKS_PER_MIN = 60
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick1Hz,
  input  logic       wrEn,
  input  logic [1:0] wrAddr,
  input  logic [7:0] wrData,
  input  logic [1:0] rdAddr,
  output logic [7:0] rdData,
  output logic       kbdResetReq,
  output logic       pwrGoodDrop,
  output logic       timeoutPulse
);
  localparam int PRESC_MAX = TICKS_PER_MIN - 1;
  localparam int PRESC_W   = $clog2(PRESC_MAX + 1);

  wdtStrobes_t      strobes;
  logic [CNT_W-1:0] counter;
  logic [PRESC_W-1:0] presc;
  logic             cntIsOne;
  logic             prescWrap;
  logic [7:0]       ctrlReg;
  logic [7:0]       cfgReg;
  logic [7:0]       hiReg;
  logic             running;

  wdt_ctrl #(
    .WIDE_COUNT  (WIDE_COUNT),
    .KEEP_CTRL_B3(KEEP_CTRL_B3)
  ) ctrlUnit (
    .clk         (clk),
    .rstN        (rstN),
    .tick1Hz     (tick1Hz),
    .wrEn        (wrEn),
    .wrAddr      (wrAddr),
    .wrData      (wrData),
    .cntIsOne    (cntIsOne),
    .prescWrap   (prescWrap),
    .strobes     (strobes),
    .ctrlReg     (ctrlReg),
    .cfgReg      (cfgReg),
    .hiReg       (hiReg),
    .running     (running),
    .kbdResetReq (kbdResetReq),
    .pwrGoodDrop (pwrGoodDrop),
    .timeoutPulse(timeoutPulse)
  );

  wdt_datapath #(
    .PRESC_MAX(PRESC_MAX)
  ) dataUnit (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .counter  (counter),
    .presc    (presc),
    .cntIsOne (cntIsOne),
    .prescWrap(prescWrap)
  );

  always_comb begin
    unique case (rdAddr)
      ADDR_CTRL:   rdData = ctrlReg;
      ADDR_CFG:    rdData = cfgReg;
      ADDR_CNT_LO: rdData = counter[7:0];
      default:     rdData = WIDE_COUNT ? counter[15:8] : 8'h00;
    endcase
  end
endmodule

// File: rtl/wdt_checker.sv
module wdt_checker #(
  parameter bit WIDE_COUNT = 1'b1,
  parameter int PRESC_MAX  = 59,
  parameter int PRESC_W    = 6
) (
  input logic               clk,
  input logic               rstN,
  input logic               wrEn,
  input logic [1:0]         wrAddr,
  input logic [7:0]         wrData,
  input logic [7:0]         hiReg,
  input logic [7:0]         ctrlReg,
  input logic               running,
  input logic [15:0]        counter,
  input logic [PRESC_W-1:0] presc,
  input logic               kbdResetReq,
  input logic               pwrGoodDrop,
  input logic               timeoutPulse
);
  logic lowWrite;
  assign lowWrite = wrEn && (wrAddr == 2'd2);

  assert_load_starts_R2: assert property (@(posedge clk) disable iff (!rstN)
    (lowWrite && wrData != 8'h00) |=> (running && counter != 16'h0000));

  assert_zero_stops_R3: assert property (@(posedge clk) disable iff (!rstN)
    (lowWrite && wrData == 8'h00 && (!WIDE_COUNT || hiReg == 8'h00)) |=> !running);

  assert_no_count_up_R4: assert property (@(posedge clk) disable iff (!rstN)
    !$past(lowWrite) |-> (counter <= $past(counter)));

  assert_presc_range_R5: assert property (@(posedge clk) disable iff (!rstN)
    32'(presc) <= PRESC_MAX);

  assert_stopped_after_expiry_R6: assert property (@(posedge clk) disable iff (!rstN)
    (kbdResetReq || pwrGoodDrop || timeoutPulse) |-> (!running && counter == 16'h0000 && ctrlReg[0]));

  assert_status_sticky_R6: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlReg[0] && !(wrEn && wrAddr == 2'd0 && wrData[0])) |=> ctrlReg[0]);

  assert_kbd_single_R7: assert property (@(posedge clk) disable iff (!rstN)
    kbdResetReq |=> !kbdResetReq);

  assert_pgood_single_R8: assert property (@(posedge clk) disable iff (!rstN)
    pwrGoodDrop |=> !pwrGoodDrop);

  assert_tout_single_R8: assert property (@(posedge clk) disable iff (!rstN)
    timeoutPulse |=> !timeoutPulse);

  assert_narrow_high_zero_R10: assert property (@(posedge clk) disable iff (!rstN)
    !WIDE_COUNT |-> (counter[15:8] == 8'h00));
endmodule

bind sec_min_watchdog wdt_checker #(
  .WIDE_COUNT(WIDE_COUNT),
  .PRESC_MAX (PRESC_MAX),
  .PRESC_W   (PRESC_W)
) chk (
  .clk         (clk),
  .rstN        (rstN),
  .wrEn        (wrEn),
  .wrAddr      (wrAddr),
  .wrData      (wrData),
  .hiReg       (hiReg),
  .ctrlReg     (ctrlReg),
  .running     (running),
  .counter     (counter),
  .presc       (presc),
  .kbdResetReq (kbdResetReq),
  .pwrGoodDrop (pwrGoodDrop),
  .timeoutPulse(timeoutPulse)
);

// File: tb/sec_min_watchdog_test.sv
module sec_min_watchdog_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tick1Hz = 1'b0;
  logic wrEn = 1'b0;
  logic [1:0] wrAddr = 2'd0;
  logic [7:0] wrData = 8'h00;
  logic [1:0] rdAddr = 2'd0;
  logic [7:0] rdData, nRdData;
  logic kbd, pg, tout, nKbd, nPg, nTout;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  sec_min_watchdog uut (
    .clk(clk), .rstN(rstN), .tick1Hz(tick1Hz), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .rdAddr(rdAddr), .rdData(rdData),
    .kbdResetReq(kbd), .pwrGoodDrop(pg), .timeoutPulse(tout));

  sec_min_watchdog #(.WIDE_COUNT(1'b0), .KEEP_CTRL_B3(1'b1)) uutNarrow (
    .clk(clk), .rstN(rstN), .tick1Hz(tick1Hz), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .rdAddr(rdAddr), .rdData(nRdData),
    .kbdResetReq(nKbd), .pwrGoodDrop(nPg), .timeoutPulse(nTout));

  typedef struct packed {
    logic [7:0] cfg;
    logic [7:0] hi;
    logic [7:0] lo;
  } vec_t;

  localparam vec_t VECS[5] = '{
    '{cfg: 8'hC0, hi: 8'h00, lo: 8'h03},
    '{cfg: 8'h90, hi: 8'h00, lo: 8'h01},
    '{cfg: 8'hA5, hi: 8'h00, lo: 8'h05},
    '{cfg: 8'hF0, hi: 8'h01, lo: 8'h02},
    '{cfg: 8'h8A, hi: 8'h00, lo: 8'h02}
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic tick();
    @(negedge clk);
    tick1Hz = 1'b1;
    @(negedge clk);
    tick1Hz = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d, output logic [7:0] nd);
    rdAddr = a;
    #1;
    d = rdData;
    nd = nRdData;
  endtask

  task automatic runTests();
    logic [7:0] v, nv;
    logic seen;
    // R1 reset state
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), v, nv);
      check("R1 register after reset", {8'h00, v}, 16'h0000);
    end
    check("R1 outputs after reset", {13'h0, kbd, pg, tout}, 16'h0000);

    // vector table: seconds mode, R2 R4 R6 R7 R8 R9
    for (int i = 0; i < 5; i++) begin
      logic [15:0] n;
      n = {VECS[i].hi, VECS[i].lo};
      wr(2'd1, VECS[i].cfg);
      wr(2'd3, VECS[i].hi);
      wr(2'd2, VECS[i].lo);
      rd(2'd3, v, nv);
      check("R2 high byte of loaded count", {8'h00, v}, {8'h00, VECS[i].hi});
      seen = 1'b0;
      for (int k = 1; k < int'(n); k++) begin
        tick();
        if (kbd || pg || tout) seen = 1'b1;
      end
      check("R4 no early expiry", {15'h0, seen}, 16'h0000);
      rd(2'd2, v, nv);
      check("R4 one tick remaining", {8'h00, v}, 16'h0001);
      tick();
      check("R7 kbd pulse per cfg bit6", {15'h0, kbd}, {15'h0, VECS[i].cfg[6]});
      check("R8 pgood pulse per cfg bit4", {15'h0, pg}, {15'h0, VECS[i].cfg[4]});
      check("R8 timeout pulse per cfg bit5", {15'h0, tout}, {15'h0, VECS[i].cfg[5]});
      rd(2'd0, v, nv);
      check("R6 status set on expiry", {15'h0, v[0]}, 16'h0001);
      rd(2'd2, v, nv);
      check("R6 counter at zero", {8'h00, v}, 16'h0000);
      rd(2'd1, v, nv);
      check("R9 cfg readback", {8'h00, v}, {8'h00, VECS[i].cfg});
      @(negedge clk);
      check("R7 single-cycle pulses", {13'h0, kbd, pg, tout}, 16'h0000);
      tick();
      check("R6 no pulse after expiry", {13'h0, kbd, pg, tout}, 16'h0000);
      wr(2'd0, 8'h00);
      rd(2'd0, v, nv);
      check("R6 write 0 keeps status", {15'h0, v[0]}, 16'h0001);
      wr(2'd0, 8'h01);
      rd(2'd0, v, nv);
      check("R6 write 1 clears status", {15'h0, v[0]}, 16'h0000);
    end

    // R5 minutes mode, count 2
    wr(2'd1, 8'h40);
    wr(2'd3, 8'h00);
    wr(2'd2, 8'h02);
    repeat (59) tick();
    rd(2'd2, v, nv);
    check("R5 no decrement before 60 ticks", {8'h00, v}, 16'h0002);
    tick();
    rd(2'd2, v, nv);
    check("R5 decrement on 60th tick", {8'h00, v}, 16'h0001);
    seen = 1'b0;
    for (int k = 0; k < 59; k++) begin
      tick();
      if (kbd) seen = 1'b1;
    end
    check("R5 no expiry before tick 120", {15'h0, seen}, 16'h0000);
    tick();
    check("R5 expiry on tick 120", {15'h0, kbd}, 16'h0001);
    wr(2'd0, 8'h01);

    // R5 prescaler cleared on reload
    wr(2'd2, 8'h01);
    repeat (30) tick();
    wr(2'd2, 8'h01);
    seen = 1'b0;
    for (int k = 0; k < 59; k++) begin
      tick();
      if (kbd) seen = 1'b1;
    end
    check("R5 reload clears partial minute", {15'h0, seen}, 16'h0000);
    tick();
    check("R5 expiry a full minute after reload", {15'h0, kbd}, 16'h0001);
    wr(2'd0, 8'h01);

    // R3 stop by zero count
    wr(2'd1, 8'hF0);
    wr(2'd2, 8'h05);
    repeat (2) tick();
    rd(2'd2, v, nv);
    check("R3 running before stop", {8'h00, v}, 16'h0003);
    wr(2'd2, 8'h00);
    rd(2'd2, v, nv);
    check("R3 counter zero after stop", {8'h00, v}, 16'h0000);
    seen = 1'b0;
    for (int k = 0; k < 8; k++) begin
      tick();
      if (kbd || pg || tout) seen = 1'b1;
    end
    check("R3 no pulse while stopped", {15'h0, seen}, 16'h0000);
    rd(2'd0, v, nv);
    check("R3 no status while stopped", {15'h0, v[0]}, 16'h0000);

    // R12 write collides with tick
    wr(2'd1, 8'hC0);
    wr(2'd2, 8'h04);
    tick();
    @(negedge clk);
    tick1Hz = 1'b1; wrEn = 1'b1; wrAddr = 2'd2; wrData = 8'h07;
    @(negedge clk);
    tick1Hz = 1'b0; wrEn = 1'b0;
    rd(2'd2, v, nv);
    check("R12 write wins over tick", {8'h00, v}, 16'h0007);
    seen = 1'b0;
    for (int k = 0; k < 6; k++) begin
      tick();
      if (kbd) seen = 1'b1;
    end
    check("R12 no early expiry after collision", {15'h0, seen}, 16'h0000);
    tick();
    check("R12 expiry on 7th tick", {15'h0, kbd}, 16'h0001);
    wr(2'd0, 8'h01);

    // R10 narrow variant ignores high byte
    wr(2'd3, 8'h05);
    wr(2'd2, 8'h03);
    rd(2'd2, v, nv);
    check("R10 narrow low byte", {8'h00, nv}, 16'h0003);
    rd(2'd3, v, nv);
    check("R10 narrow high reads 0", {8'h00, nv}, 16'h0000);
    check("R2 wide high byte loaded", {8'h00, v}, 16'h0005);
    repeat (2) tick();
    check("R10 narrow no early expiry", {15'h0, nKbd}, 16'h0000);
    tick();
    check("R10 narrow expires on 3rd tick", {15'h0, nKbd}, 16'h0001);
    wr(2'd0, 8'h01);

    // R11 sticky control bit 3
    wr(2'd0, 8'h08);
    rd(2'd0, v, nv);
    check("R11 default bit3 set", {8'h00, v}, 16'h0008);
    check("R11 keep variant bit3 set", {8'h00, nv}, 16'h0008);
    wr(2'd0, 8'h00);
    rd(2'd0, v, nv);
    check("R11 default bit3 cleared", {8'h00, v}, 16'h0000);
    check("R11 keep variant bit3 kept", {8'h00, nv}, 16'h0008);
  endtask

  initial begin
    fork
      runTests();
      begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog (all requirements) actual=hung expected=finished");
      end
    join_any
    disable fork;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule